// File: doc/BRIEF.md
# Thread-Block Admission Controller

This block sits in front of one multiprocessor and decides when a whole thread block may start there. A dispatcher offers one block descriptor at a time. The descriptor gives a thread count, the registers each thread needs and the bytes of shared memory the block needs. The controller looks at four budgets together: register file entries, shared-memory granules, resident-block slots and resident-warp slots. It accepts the block only when all four budgets can cover it in the same cycle. It then charges every budget in that one step and returns the index of the slot that now holds the block.

A block that could fit later is back-pressured: the dispatcher keeps it on the input until a retirement frees enough room. A block that can never fit is taken at once and answered with an error, so the dispatcher is never stalled by it. The retire port names a slot, and the controller gives back exactly what that slot was charged. Resident warps are reported both as a raw count and as a percentage of the warp limit.

Input handshake rules:
- A transfer happens on a rising edge where `in_valid` and `in_ready` are both high.
- Once `in_valid` is raised, it stays high and the descriptor stays unchanged until that transfer.
- `in_ready` is combinational. It may depend on the descriptor on offer and on a retirement in the same cycle.
- The response output has no back-pressure. It is a one-cycle pulse.

Top module: `blk_admit_ctrl`

## Requirements
- R1: A block is accepted only when its warp charge, register charge, granule charge and one free slot are all available in the same cycle. All four are charged together on that transfer, and the slot it receives reads as occupied from then on.
- R2: A block that fails the fit check, but is not a never-fit block, is held: `in_ready` stays low for as long as the resources are missing, and no response is produced.
- R3: A never-fit block is accepted immediately with `rsp_err`=1 and charges nothing. A block is never-fit when any of these holds: thread count 0, thread count above MAX_THR (1024), threads×regs above REG_POOL, or rounded shared memory above SMEM_BYTES.
- R4: The warp charge is ceil(threads/32). For example, 33 threads cost 2 warps and 1023 threads cost 32 warps.
- R5: The register charge is threads × registers-per-thread against a pool of 65536. A block that needs exactly the whole free pool is accepted.
- R6: Shared memory is charged in 128-byte granules, with the byte count rounded up. The pool is SMEM_BYTES (default 233472 bytes, i.e. 1824 granules). A request that exactly fills the pool is accepted.
- R7: At most 32 blocks are resident. With all slots full, any further fitting-size block is held.
- R8: At most 64 warps are resident. A block that would exceed 64 warps is held.
- R9: An accepted block gets the lowest-numbered free slot.
- R10: Retiring an occupied slot returns exactly the resources charged to it. Retiring a free slot changes nothing.
- R11: When a retirement and an offer happen in the same cycle, the retirement is applied first. The fit check and the slot choice both see the freed resources.
- R12: `occ_warps` is the resident warp count and `occ_pct` = floor(occ_warps×100/64). After reset both are 0. With 32 blocks of 32 threads resident, they read 32 and 50.
- R13: Every transfer produces `rsp_valid` in the following cycle, together with `rsp_err` and `rsp_slot`. `rsp_slot` is 0 on an error. Without a transfer, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A descriptor is on offer |
| in_ready | output | 1 | The controller accepts the descriptor on offer |
| in_threads | input | 11 | Thread count of the block |
| in_regs | input | 8 | Registers per thread |
| in_smem | input | 18 | Shared-memory bytes for the block |
| rsp_valid | output | 1 | One-cycle pulse after each transfer |
| rsp_err | output | 1 | The block was never-fit and was dropped |
| rsp_slot | output | 5 | Slot given to the accepted block |
| ret_valid | input | 1 | Retire the slot on `ret_slot` this cycle |
| ret_slot | input | 5 | Slot being retired |
| occ_warps | output | 7 | Resident warp count |
| occ_pct | output | 7 | Occupancy in whole percent of the warp limit |

## Verification
The bench builds the controller with its default parameters: 32 slots, 64 warps, 1024 threads per block, 65536 registers and 233472 bytes of shared memory in 128-byte granules. These are the real limits, so every budget can be driven to its exact edge within a few dozen transfers. The bench fills all 32 slots, reaches the 64-warp ceiling with two 1024-thread blocks, consumes the whole register pool with one block, and fills the granule pool to its last granule. With these values it can hold a block on each resource in turn, and then release it by a retirement in the same cycle.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

  // Outcome of one offer as seen by the response stage.
  typedef enum logic [1:0] {
    ADM_IDLE  = 2'd0,
    ADM_GRANT = 2'd1,
    ADM_DROP  = 2'd2
  } adm_kind_e;

  // Ceiling division used for warp and granule charges.
  function automatic logic [31:0] ceil_div(input logic [31:0] num, input int unsigned den);
    return (num + 32'(den) - 32'd1) / 32'(den);
  endfunction

endpackage

// File: rtl/blk_admit_cost.sv
// Turns a descriptor into per-resource charges and flags never-fit requests.
module blk_admit_cost #(
  parameter int MAX_THR   = 1024,
  parameter int WARP_SIZE = 32,
  parameter int REG_POOL  = 65536,
  parameter int GPOOL     = 1824,
  parameter int SMEM_GRAN = 128,
  parameter int TW        = 11,
  parameter int RW        = 8,
  parameter int SW        = 18,
  parameter int WCW       = 7,
  parameter int RCW       = 17,
  parameter int GCW       = 11
) (
  input  logic [TW-1:0]  threads,
  input  logic [RW-1:0]  regs,
  input  logic [SW-1:0]  smem,
  output logic [WCW-1:0] warp_need,
  output logic [RCW-1:0] reg_need,
  output logic [GCW-1:0] gran_need,
  output logic           never_fit
);
  import blk_admit_pkg::*;

  logic [31:0] w32, r32, g32;
  logic        no_thr, thr_over, reg_over, smem_over;

  always_comb begin
    w32       = ceil_div(32'(threads), WARP_SIZE);
    r32       = 32'(threads) * 32'(regs);
    g32       = ceil_div(32'(smem), SMEM_GRAN);
    no_thr    = (threads == '0);
    thr_over  = (32'(threads) > 32'(MAX_THR));
    reg_over  = (r32 > 32'(REG_POOL));
    smem_over = (g32 > 32'(GPOOL));
    never_fit = no_thr | thr_over | reg_over | smem_over;
    warp_need = never_fit ? '0 : WCW'(w32);
    reg_need  = never_fit ? '0 : RCW'(r32);
    gran_need = never_fit ? '0 : GCW'(g32);
  end

endmodule

// File: rtl/blk_admit_meter.sv
// One resource budget: a level counter with retire-first fit check.
module blk_admit_meter #(
  parameter int LIMIT = 64,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] give,
  input  logic         take_en,
  input  logic [W-1:0] take,
  output logic         fits,
  output logic [W-1:0] level
);
  logic [W-1:0] level_q;
  logic [W-1:0] after_give;
  logic [31:0]  sum;

  always_comb begin
    after_give = level_q - give;
    sum        = 32'(after_give) + 32'(take);
    fits       = (sum <= 32'(LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= after_give + (take_en ? take : '0);
  end

  assign level = level_q;

endmodule

// File: rtl/blk_admit_slots.sv
// Slot table: occupancy bits, per-slot charge records, lowest-free pick.
module blk_admit_slots #(
  parameter int MAX_BLOCKS = 32,
  parameter int SLOTW      = 5,
  parameter int WCW        = 7,
  parameter int RCW        = 17,
  parameter int GCW        = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  claim,
  input  logic [WCW-1:0]        claim_w,
  input  logic [RCW-1:0]        claim_r,
  input  logic [GCW-1:0]        claim_g,
  input  logic                  rel_req,
  input  logic [SLOTW-1:0]      rel_slot,
  output logic [MAX_BLOCKS-1:0] busy,
  output logic                  free_any,
  output logic [SLOTW-1:0]      free_slot,
  output logic                  rel_hit,
  output logic [WCW-1:0]        rel_w,
  output logic [RCW-1:0]        rel_r,
  output logic [GCW-1:0]        rel_g
);
  logic [WCW-1:0]        rec_w [MAX_BLOCKS];
  logic [RCW-1:0]        rec_r [MAX_BLOCKS];
  logic [GCW-1:0]        rec_g [MAX_BLOCKS];
  logic [MAX_BLOCKS-1:0] rel_mask;
  logic [MAX_BLOCKS-1:0] busy_eff;
  logic                  rel_in;

  for (genvar i = 0; i < MAX_BLOCKS; i++) begin : g_slot
    logic           b_q;
    logic [WCW-1:0] w_q;
    logic [RCW-1:0] r_q;
    logic [GCW-1:0] g_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= 1'b0;
        w_q <= '0;
        r_q <= '0;
        g_q <= '0;
      end else if (claim && free_slot == SLOTW'(i)) begin
        b_q <= 1'b1;
        w_q <= claim_w;
        r_q <= claim_r;
        g_q <= claim_g;
      end else if (rel_mask[i]) begin
        b_q <= 1'b0;
      end
    end

    assign busy[i]     = b_q;
    assign rec_w[i]    = w_q;
    assign rec_r[i]    = r_q;
    assign rec_g[i]    = g_q;
    assign rel_mask[i] = rel_hit && (rel_slot == SLOTW'(i));
  end

  always_comb begin
    rel_in  = (32'(rel_slot) < 32'(MAX_BLOCKS));
    rel_hit = rel_req && rel_in && busy[rel_slot];
    rel_w   = rel_hit ? rec_w[rel_slot] : '0;
    rel_r   = rel_hit ? rec_r[rel_slot] : '0;
    rel_g   = rel_hit ? rec_g[rel_slot] : '0;
  end

  // Retire-first view of the table, then the lowest free index.
  assign busy_eff = busy & ~rel_mask;

  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--) begin
      if (!busy_eff[i]) begin
        free_any  = 1'b1;
        free_slot = SLOTW'(i);
      end
    end
  end

endmodule

// File: rtl/blk_admit_ctrl.sv
// Top: thread-block admission with joint resource reservation.
module blk_admit_ctrl #(
  parameter int MAX_BLOCKS = 32,
  parameter int MAX_WARPS  = 64,
  parameter int MAX_THR    = 1024,
  parameter int WARP_SIZE  = 32,
  parameter int REG_POOL   = 65536,
  parameter int SMEM_BYTES = 233472,
  parameter int SMEM_GRAN  = 128,
  parameter int RW         = 8,
  parameter int SW         = 18,
  localparam int TW        = $clog2(2 * MAX_THR),
  localparam int SLOTW     = $clog2(MAX_BLOCKS),
  localparam int WCW       = $clog2(MAX_WARPS + 1),
  localparam int RCW       = $clog2(REG_POOL + 1),
  localparam int GPOOL     = SMEM_BYTES / SMEM_GRAN,
  localparam int GCW       = $clog2(GPOOL + 1),
  localparam int PCTW      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TW-1:0]    in_threads,
  input  logic [RW-1:0]    in_regs,
  input  logic [SW-1:0]    in_smem,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [SLOTW-1:0] rsp_slot,
  input  logic             ret_valid,
  input  logic [SLOTW-1:0] ret_slot,
  output logic [WCW-1:0]   occ_warps,
  output logic [PCTW-1:0]  occ_pct
);
  import blk_admit_pkg::*;

  logic [WCW-1:0]        warp_need, rel_w, used_w;
  logic [RCW-1:0]        reg_need, rel_r, used_r;
  logic [GCW-1:0]        gran_need, rel_g, used_g;
  logic                  never_fit, free_any, rel_hit;
  logic                  fit_w, fit_r, fit_g, fit_all;
  logic [SLOTW-1:0]      free_slot;
  logic [MAX_BLOCKS-1:0] slot_busy;
  logic                  hs, claim;
  adm_kind_e             kind;
  logic [SLOTW-1:0]      slot_q;
  adm_kind_e             kind_q;
  logic [31:0]           pct32;

  blk_admit_cost #(
    .MAX_THR(MAX_THR), .WARP_SIZE(WARP_SIZE), .REG_POOL(REG_POOL), .GPOOL(GPOOL),
    .SMEM_GRAN(SMEM_GRAN), .TW(TW), .RW(RW), .SW(SW), .WCW(WCW), .RCW(RCW), .GCW(GCW)
  ) u_cost (
    .threads(in_threads), .regs(in_regs), .smem(in_smem),
    .warp_need(warp_need), .reg_need(reg_need), .gran_need(gran_need),
    .never_fit(never_fit)
  );

  blk_admit_slots #(
    .MAX_BLOCKS(MAX_BLOCKS), .SLOTW(SLOTW), .WCW(WCW), .RCW(RCW), .GCW(GCW)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .claim(claim), .claim_w(warp_need), .claim_r(reg_need), .claim_g(gran_need),
    .rel_req(ret_valid), .rel_slot(ret_slot),
    .busy(slot_busy), .free_any(free_any), .free_slot(free_slot),
    .rel_hit(rel_hit), .rel_w(rel_w), .rel_r(rel_r), .rel_g(rel_g)
  );

  blk_admit_meter #(.LIMIT(MAX_WARPS), .W(WCW)) u_warps (
    .clk(clk), .rst_n(rst_n), .give(rel_w), .take_en(claim), .take(warp_need),
    .fits(fit_w), .level(used_w)
  );

  blk_admit_meter #(.LIMIT(REG_POOL), .W(RCW)) u_regs (
    .clk(clk), .rst_n(rst_n), .give(rel_r), .take_en(claim), .take(reg_need),
    .fits(fit_r), .level(used_r)
  );

  blk_admit_meter #(.LIMIT(GPOOL), .W(GCW)) u_smem (
    .clk(clk), .rst_n(rst_n), .give(rel_g), .take_en(claim), .take(gran_need),
    .fits(fit_g), .level(used_g)
  );

  always_comb begin
    fit_all  = free_any & fit_w & fit_r & fit_g;
    in_ready = never_fit | fit_all;
    hs       = in_valid & in_ready;
    claim    = hs & ~never_fit;
    if (!hs)            kind = ADM_IDLE;
    else if (never_fit) kind = ADM_DROP;
    else                kind = ADM_GRANT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= ADM_IDLE;
      slot_q <= '0;
    end else begin
      kind_q <= kind;
      slot_q <= (kind == ADM_GRANT) ? free_slot : '0;
    end
  end

  assign rsp_valid = (kind_q != ADM_IDLE);
  assign rsp_err   = (kind_q == ADM_DROP);
  assign rsp_slot  = slot_q;

  // Register and granule levels only gate admission; they are not exported.
  logic unused_levels;
  assign unused_levels = ^{used_r, used_g, rel_hit};

  always_comb begin
    pct32     = (32'(used_w) * 32'd100) / 32'(MAX_WARPS);
    occ_warps = used_w;
    occ_pct   = PCTW'(pct32);
  end

endmodule

// File: rtl/blk_admit_chk.sv
// Property checker bound onto the admission controller.
module blk_admit_chk #(
  parameter int MAX_BLOCKS = 32,
  parameter int MAX_WARPS  = 64,
  parameter int MAX_THR    = 1024,
  parameter int TW         = 11,
  parameter int RW         = 8,
  parameter int SW         = 18,
  parameter int SLOTW      = 5,
  parameter int WCW        = 7,
  parameter int PCTW       = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [TW-1:0]         in_threads,
  input logic [RW-1:0]         in_regs,
  input logic [SW-1:0]         in_smem,
  input logic                  rsp_valid,
  input logic                  rsp_err,
  input logic [SLOTW-1:0]      rsp_slot,
  input logic                  ret_valid,
  input logic [WCW-1:0]        occ_warps,
  input logic [PCTW-1:0]       occ_pct,
  input logic [MAX_BLOCKS-1:0] busy
);

  assert_rsp_after_xfer_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> rsp_valid);

  assert_no_stray_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !rsp_valid);

  assert_oversize_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && 32'(in_threads) > 32'(MAX_THR)) |-> in_ready);

  assert_oversize_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && 32'(in_threads) > 32'(MAX_THR)) |=> (rsp_valid && rsp_err));

  assert_drop_no_charge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && !$past(ret_valid)) |-> (occ_warps == $past(occ_warps)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_warps) <= 32'(MAX_WARPS));

  assert_full_pct_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(occ_warps) == 32'(MAX_WARPS)) |-> (32'(occ_pct) == 32'd100));

  assert_slots_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&busy) && !ret_valid && in_valid && in_threads != '0 &&
     32'(in_threads) <= 32'(MAX_THR) && in_regs == '0 && in_smem == '0) |-> !in_ready);

  assert_granted_slot_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> busy[rsp_slot]);

endmodule

bind blk_admit_ctrl blk_admit_chk #(
  .MAX_BLOCKS(MAX_BLOCKS), .MAX_WARPS(MAX_WARPS), .MAX_THR(MAX_THR),
  .TW(TW), .RW(RW), .SW(SW), .SLOTW(SLOTW), .WCW(WCW), .PCTW(PCTW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_threads(in_threads), .in_regs(in_regs), .in_smem(in_smem),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_slot(rsp_slot),
  .ret_valid(ret_valid), .occ_warps(occ_warps), .occ_pct(occ_pct),
  .busy(slot_busy)
);

// File: tb/blk_admit_ctrl_tb.sv
module blk_admit_ctrl_tb;
  localparam int TW = 11, RW = 8, SW = 18, SLOTW = 5, WCW = 7, PCTW = 7;
  localparam int HALF = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [TW-1:0]    in_threads = '0;
  logic [RW-1:0]    in_regs = '0;
  logic [SW-1:0]    in_smem = '0;
  logic             rsp_valid, rsp_err;
  logic [SLOTW-1:0] rsp_slot;
  logic             ret_valid = 1'b0;
  logic [SLOTW-1:0] ret_slot = '0;
  logic [WCW-1:0]   occ_warps;
  logic [PCTW-1:0]  occ_pct;

  int total = 0;
  int bad = 0;

  always #HALF clk = ~clk;

  blk_admit_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_threads(in_threads), .in_regs(in_regs), .in_smem(in_smem),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_slot(rsp_slot),
    .ret_valid(ret_valid), .ret_slot(ret_slot),
    .occ_warps(occ_warps), .occ_pct(occ_pct)
  );

  // threads, regs/thread, smem bytes, exp_err, exp_slot, exp_warps after
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{  32,  16,      0, 0, 0,  1},   // R1 R4
    '{1024,  32,   4096, 0, 1, 33},   // R5 R9
    '{1025,   1,      0, 1, 0, 33},   // R3 too many threads
    '{  33,   1,      1, 0, 2, 35},   // R4 R6 rounding
    '{   0,   8,      0, 1, 0, 35},   // R3 empty block
    '{  64, 255,      0, 0, 3, 37},   // R5
    '{  32,   0, 240000, 1, 0, 37},   // R3 smem over pool
    '{  32,   1, 229248, 0, 4, 38}    // R6 pool filled exactly
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    ret_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic offer(input int t, input int r, input int s);
    in_threads = TW'(t);
    in_regs    = RW'(r);
    in_smem    = SW'(s);
    in_valid   = 1'b1;
  endtask

  // Offer, take the transfer on the next edge, report the response.
  task automatic send(input int t, input int r, input int s,
                      output int rdy, output int rv, output int err, output int slot);
    offer(t, r, s);
    #1 rdy = int'(in_ready);
    @(posedge clk);
    #2 in_valid = 1'b0;
    rv = int'(rsp_valid); err = int'(rsp_err); slot = int'(rsp_slot);
  endtask

  task automatic expect_grant(input string req, input int t, input int r, input int s,
                              input int exp_slot);
    int rdy, rv, err, slot;
    send(t, r, s, rdy, rv, err, slot);
    check(req, "ready", rdy, 1);
    check(req, "rsp_valid", rv, 1);
    check(req, "rsp_err", err, 0);
    check(req, "rsp_slot", slot, exp_slot);
  endtask

  // Present a non-fitting block for n cycles; ready and rsp stay low.
  task automatic expect_hold(input string req, input int t, input int r, input int s, input int n);
    offer(t, r, s);
    for (int c = 0; c < n; c++) begin
      #1 check(req, "held ready", int'(in_ready), 0);
      @(posedge clk);
      #2 check(req, "held rsp_valid", int'(rsp_valid), 0);
    end
  endtask

  task automatic retire(input int slot);
    ret_valid = 1'b1;
    ret_slot  = SLOTW'(slot);
    @(posedge clk);
    #2 ret_valid = 1'b0;
  endtask

  initial begin
    #(2 * HALF * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rdy, rv, err, slot;
    do_reset();
    check("R12", "reset occ_warps", int'(occ_warps), 0);
    check("R12", "reset occ_pct", int'(occ_pct), 0);
    check("R13", "reset rsp_valid", int'(rsp_valid), 0);

    // Vector walk from an empty controller.
    for (int k = 0; k < NV; k++) begin
      send(VEC[k][0], VEC[k][1], VEC[k][2], rdy, rv, err, slot);
      check("R1 R3 R13", "vec ready", rdy, 1);
      check("R13", "vec rsp_valid", rv, 1);
      check("R3", "vec rsp_err", err, VEC[k][3]);
      check("R9", "vec rsp_slot", slot, VEC[k][4]);
      check("R4 R10", "vec occ_warps", int'(occ_warps), VEC[k][5]);
      check("R12", "vec occ_pct", int'(occ_pct), VEC[k][5] * 100 / 64);
    end

    // R6 R2: pool full, a 1-byte request needs a granule and waits.
    expect_hold("R6 R2", 32, 0, 1, 3);
    // R11: retire slot 2 (one granule) in the same cycle.
    ret_valid = 1'b1; ret_slot = SLOTW'(2);
    #1 check("R11", "ready with retire", int'(in_ready), 1);
    @(posedge clk);
    #2 in_valid = 1'b0; ret_valid = 1'b0;
    check("R11", "rsp_valid", int'(rsp_valid), 1);
    check("R9", "reused slot", int'(rsp_slot), 2);
    check("R10", "warps after swap", int'(occ_warps), 37);
    check("R12", "pct 37 warps", int'(occ_pct), 57);

    // R10: return exact charge, ignore a free slot.
    retire(1);
    check("R10", "warps after retire", int'(occ_warps), 5);
    check("R12", "pct 5 warps", int'(occ_pct), 7);
    retire(1);
    check("R10", "free-slot retire", int'(occ_warps), 5);
    retire(9);
    check("R10", "never-used retire", int'(occ_warps), 5);

    // R7 R12: fill every slot with 32-thread blocks.
    do_reset();
    for (int i = 0; i < 32; i++) expect_grant("R9 R7", 32, 0, 0, i);
    check("R12", "half warps", int'(occ_warps), 32);
    check("R12", "half pct", int'(occ_pct), 50);
    expect_hold("R7", 32, 0, 0, 2);
    ret_valid = 1'b1; ret_slot = SLOTW'(5);
    #1 check("R11", "slot freed same cycle", int'(in_ready), 1);
    @(posedge clk);
    #2 in_valid = 1'b0; ret_valid = 1'b0;
    check("R9", "freed slot chosen", int'(rsp_slot), 5);
    check("R10", "warps steady", int'(occ_warps), 32);

    // R8 R4: warp ceiling.
    do_reset();
    expect_grant("R4", 1023, 0, 0, 0);
    check("R4", "1023 threads", int'(occ_warps), 32);
    expect_grant("R8", 1024, 0, 0, 1);
    check("R8", "full warps", int'(occ_warps), 64);
    check("R12", "full pct", int'(occ_pct), 100);
    expect_hold("R8", 32, 0, 0, 2);
    in_valid = 1'b0;
    @(posedge clk); #2;

    // R5 R3: register pool.
    do_reset();
    expect_grant("R5", 1024, 64, 0, 0);
    expect_hold("R5", 32, 1, 0, 2);
    in_valid = 1'b0;
    @(posedge clk); #2;
    expect_grant("R5", 32, 0, 0, 1);
    check("R5", "warps", int'(occ_warps), 33);
    send(1024, 65, 0, rdy, rv, err, slot);
    check("R3", "reg never-fit ready", rdy, 1);
    check("R3", "reg never-fit err", err, 1);
    check("R3", "reg never-fit slot", slot, 0);
    check("R3", "no charge", int'(occ_warps), 33);
    @(posedge clk);
    #2 check("R13", "pulse ends", int'(rsp_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule